// File: doc/BRIEF.md
# Accumulator Datapath with Adder, Logic and Link Bit

This block holds a 16-bit accumulator and a one-bit link flip-flop that widens it for carries and rotations. Each cycle it looks at the decoded opcode lines, the indirect bit, two timing strobes and the low twelve instruction bits. From these it picks at most one update. The update comes from a bitwise logic and ripple-carry stage that is built once per bit position. The operands are the data register and an 8-bit character register.

The memory-reference group gives three operations: AND, add and load. All three take their operand from the data register and act when the execute strobe arrives with opcode line 0, 1 or 2. The register-reference group acts when the register strobe arrives with opcode line 7 and the indirect bit low. In this group the instruction bits select clears, complements, rotations through the link bit and an increment. The same group also evaluates four skip tests and a halt bit. These come out combinationally during that cycle, so a sequencer can advance its program counter or stop. The I/O group acts when the register strobe arrives with opcode line 7 and the indirect bit high. This block handles only one I/O case: bit 11 copies the character register into the low accumulator byte.

Top module: `accum_unit`

## Requirements
- R1: After reset the accumulator reads 0x0000 and the link bit reads 0.
- R2: When the execute strobe and opcode line 0 are both high, the accumulator takes its bitwise AND with the data register on the next clock. The link bit does not change.
- R3: When the execute strobe and opcode line 1 are both high, the accumulator takes the 16-bit sum of itself and the data register, and the link bit takes the carry out of bit 15.
- R4: When the execute strobe and opcode line 2 are both high, the accumulator is loaded from the data register. The link bit does not change.
- R5: When the register strobe, opcode line 7, the indirect bit and instruction bit 11 are all high, the character register is copied into accumulator bits 7..0. Bits 15..8 and the link bit keep their values. No other I/O instruction bit changes the accumulator or the link bit.
- R6: In a register-reference cycle, instruction bit 11 clears the accumulator and bit 10 clears the link bit.
- R7: In a register-reference cycle, bit 9 inverts every accumulator bit and bit 8 inverts the link bit.
- R8: In a register-reference cycle, bit 7 rotates right through the link bit. Accumulator bit 15 takes the old link value, each lower bit takes its upper neighbour, and the link bit takes old bit 0.
- R9: In a register-reference cycle, bit 6 rotates left through the link bit. Bit 0 takes the old link value, each higher bit takes its lower neighbour, and the link bit takes old bit 15.
- R10: In a register-reference cycle, bit 5 adds one to the accumulator. 0xFFFF wraps to 0x0000, and the link bit does not change.
- R11: When several of bits 11..5 are set in one register-reference cycle, only the highest-numbered set bit takes effect.
- R12: The skip output is high only during a register-reference cycle. It is then the OR of the enabled tests: bit 4 with accumulator bit 15 equal to 0, bit 3 with bit 15 equal to 1, bit 2 with an all-zero accumulator, and bit 1 with the link bit equal to 0. The skip tests do not change any state.
- R13: The halt output is high exactly when a register-reference cycle has bit 0 set.
- R14: In a cycle with no qualifying strobe combination, the accumulator and the link bit hold their values. This includes an execute strobe with opcode lines 3 to 7, and a register strobe without opcode line 7.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| op_dec_i | input | 8 | One-hot decoded opcode lines 0..7 |
| indirect_i | input | 1 | Indirect bit; separates I/O from register-reference when line 7 is high |
| exec_stb_i | input | 1 | Timing strobe for the memory-reference execute step |
| reg_stb_i | input | 1 | Timing strobe for register-reference and I/O execution |
| ir_low_i | input | 12 | Instruction bits 11..0 |
| dr_i | input | 16 | Data register operand |
| inpr_i | input | 8 | Character register operand |
| ac_o | output | 16 | Accumulator value toward the bus |
| e_o | output | 1 | Link bit |
| skip_o | output | 1 | Combined conditional-skip request |
| halt_o | output | 1 | Halt request |

## Verification
Some rules are checked by assertions on every clock. These are: the add leaves its carry in the link bit; a clear empties the accumulator; a lone increment wraps and leaves the link bit alone; a lone right rotation moves bit 0 into the link bit; and the state is held with the strobes low. The skip and halt outputs are also checked to stay low outside strobe cycles. Other rules can only be shown by the bench's sweeps over many operand values. These are: priority among mixed register bits; the character load keeping the upper byte; the other I/O bits having no effect; each skip test against the sign, zero and link conditions; and the decode combinations that must be ignored.

// File: rtl/accum_pkg.sv
package accum_pkg;

    localparam int ACC_W_DEF = 16;
    localparam int CHR_W_DEF = 8;

    // register-reference instruction bit positions (decoded by the sequencer too)
    localparam int BIT_ZAC   = 11;
    localparam int BIT_ZE    = 10;
    localparam int BIT_NAC   = 9;
    localparam int BIT_NE    = 8;
    localparam int BIT_ROR   = 7;
    localparam int BIT_ROL   = 6;
    localparam int BIT_INC   = 5;
    localparam int BIT_SKPOS = 4;
    localparam int BIT_SKNEG = 3;
    localparam int BIT_SKZ   = 2;
    localparam int BIT_SKEZ  = 1;
    localparam int BIT_HALT  = 0;
    // I/O instruction bit for the character load
    localparam int BIT_CHIN  = 11;

    typedef enum logic [3:0] {
        OP_IDLE,
        OP_ANDD,
        OP_ADDD,
        OP_LOADD,
        OP_CHIN,
        OP_ZAC,
        OP_ZE,
        OP_NAC,
        OP_NE,
        OP_ROR,
        OP_ROL,
        OP_INC
    } acop_e;

    typedef struct packed {
        acop_e op;
        logic  ac_ld;
        logic  ac_inr;
        logic  ac_clr;
        logic  e_wr;
        logic  rr_act;
    } acctl_t;

endpackage

// File: rtl/accum_decode.sv
module accum_decode
    import accum_pkg::*;
(
    input  logic [7:0]  op_dec_i,
    input  logic        indirect_i,
    input  logic        exec_stb_i,
    input  logic        reg_stb_i,
    input  logic [11:5] ir_hi_i,
    output acctl_t      ctl_o
);

    logic rr_act;
    logic io_act;

    assign rr_act = reg_stb_i & op_dec_i[7] & ~indirect_i;
    assign io_act = reg_stb_i & op_dec_i[7] &  indirect_i;

    always_comb begin
        ctl_o        = '0;
        ctl_o.op     = OP_IDLE;
        ctl_o.rr_act = rr_act;

        if (exec_stb_i) begin
            if      (op_dec_i[0]) ctl_o.op = OP_ANDD;
            else if (op_dec_i[1]) ctl_o.op = OP_ADDD;
            else if (op_dec_i[2]) ctl_o.op = OP_LOADD;
        end else if (rr_act) begin
            // highest-numbered set bit wins
            if      (ir_hi_i[BIT_ZAC]) ctl_o.op = OP_ZAC;
            else if (ir_hi_i[BIT_ZE])  ctl_o.op = OP_ZE;
            else if (ir_hi_i[BIT_NAC]) ctl_o.op = OP_NAC;
            else if (ir_hi_i[BIT_NE])  ctl_o.op = OP_NE;
            else if (ir_hi_i[BIT_ROR]) ctl_o.op = OP_ROR;
            else if (ir_hi_i[BIT_ROL]) ctl_o.op = OP_ROL;
            else if (ir_hi_i[BIT_INC]) ctl_o.op = OP_INC;
        end else if (io_act) begin
            if (ir_hi_i[BIT_CHIN]) ctl_o.op = OP_CHIN;
        end

        unique case (ctl_o.op)
            OP_ANDD, OP_ADDD, OP_LOADD, OP_CHIN,
            OP_NAC, OP_ROR, OP_ROL:  ctl_o.ac_ld  = 1'b1;
            OP_INC:                  ctl_o.ac_inr = 1'b1;
            OP_ZAC:                  ctl_o.ac_clr = 1'b1;
            default: ;
        endcase

        unique case (ctl_o.op)
            OP_ADDD, OP_ZE, OP_NE, OP_ROR, OP_ROL: ctl_o.e_wr = 1'b1;
            default: ;
        endcase
    end

endmodule

// File: rtl/accum_alu.sv
module accum_alu
    import accum_pkg::*;
#(
    parameter int ACC_W = ACC_W_DEF,
    parameter int CHR_W = CHR_W_DEF
)(
    input  acop_e              op_i,
    input  logic [ACC_W-1:0]   ac_i,
    input  logic               e_i,
    input  logic [ACC_W-1:0]   dr_i,
    input  logic [CHR_W-1:0]   inpr_i,
    output logic [ACC_W-1:0]   ac_nx_o,
    output logic               e_nx_o
);

    localparam int MSB = ACC_W - 1;

    logic [ACC_W:0]   cy;
    logic [ACC_W-1:0] ic;
    logic [ACC_W-1:0] and_v, sum_v, inc_v, ror_v, rol_v, chin_v;

    assign cy[0] = 1'b0;
    assign ic[0] = 1'b1;

    for (genvar i = 0; i < ACC_W; i++) begin : g_stage
        assign and_v[i]  = ac_i[i] & dr_i[i];
        assign sum_v[i]  = ac_i[i] ^ dr_i[i] ^ cy[i];
        assign cy[i+1]   = (ac_i[i] & dr_i[i]) | (cy[i] & (ac_i[i] ^ dr_i[i]));
        assign inc_v[i]  = ac_i[i] ^ ic[i];
        if (i < MSB) begin : g_ichain
            assign ic[i+1] = ac_i[i] & ic[i];
        end
        if (i == MSB) begin : g_rtop
            assign ror_v[i] = e_i;
        end else begin : g_rmid
            assign ror_v[i] = ac_i[i+1];
        end
        if (i == 0) begin : g_lbot
            assign rol_v[i] = e_i;
        end else begin : g_lmid
            assign rol_v[i] = ac_i[i-1];
        end
        if (i < CHR_W) begin : g_chr
            assign chin_v[i] = inpr_i[i];
        end else begin : g_keep
            assign chin_v[i] = ac_i[i];
        end
    end

    always_comb begin
        ac_nx_o = ac_i;
        e_nx_o  = e_i;
        unique case (op_i)
            OP_ANDD:  ac_nx_o = and_v;
            OP_ADDD:  begin ac_nx_o = sum_v; e_nx_o = cy[ACC_W]; end
            OP_LOADD: ac_nx_o = dr_i;
            OP_CHIN:  ac_nx_o = chin_v;
            OP_ZAC:   ac_nx_o = '0;
            OP_ZE:    e_nx_o  = 1'b0;
            OP_NAC:   ac_nx_o = ~ac_i;
            OP_NE:    e_nx_o  = ~e_i;
            OP_ROR:   begin ac_nx_o = ror_v; e_nx_o = ac_i[0]; end
            OP_ROL:   begin ac_nx_o = rol_v; e_nx_o = ac_i[MSB]; end
            OP_INC:   ac_nx_o = inc_v;
            default:  ;
        endcase
    end

endmodule

// File: rtl/accum_skip.sv
module accum_skip
    import accum_pkg::*;
#(
    parameter int ACC_W = ACC_W_DEF
)(
    input  logic             rr_act_i,
    input  logic [4:0]       ir_lo_i,
    input  logic [ACC_W-1:0] ac_i,
    input  logic             e_i,
    output logic             skip_o,
    output logic             halt_o
);

    logic ac_zero;
    logic [3:0] hit;

    assign ac_zero = ~|ac_i;

    always_comb begin
        hit[0] = ir_lo_i[BIT_SKEZ]  & ~e_i;
        hit[1] = ir_lo_i[BIT_SKZ]   &  ac_zero;
        hit[2] = ir_lo_i[BIT_SKNEG] &  ac_i[ACC_W-1];
        hit[3] = ir_lo_i[BIT_SKPOS] & ~ac_i[ACC_W-1];
        skip_o = rr_act_i & (|hit);
        halt_o = rr_act_i & ir_lo_i[BIT_HALT];
    end

endmodule

// File: rtl/accum_unit.sv
module accum_unit
    import accum_pkg::*;
#(
    parameter int ACC_W = ACC_W_DEF,
    parameter int CHR_W = CHR_W_DEF
)(
    input  logic               clk,
    input  logic               rst_n,
    input  logic [7:0]         op_dec_i,
    input  logic               indirect_i,
    input  logic               exec_stb_i,
    input  logic               reg_stb_i,
    input  logic [11:0]        ir_low_i,
    input  logic [ACC_W-1:0]   dr_i,
    input  logic [CHR_W-1:0]   inpr_i,
    output logic [ACC_W-1:0]   ac_o,
    output logic               e_o,
    output logic               skip_o,
    output logic               halt_o
);

    typedef struct packed {
        logic [ACC_W-1:0] ac;
        logic             e;
    } accst_t;

    accst_t st_d, st_q;
    acctl_t ctl;
    logic [ACC_W-1:0] alu_ac;
    logic             alu_e;

    accum_decode u_decode (
        .op_dec_i   (op_dec_i),
        .indirect_i (indirect_i),
        .exec_stb_i (exec_stb_i),
        .reg_stb_i  (reg_stb_i),
        .ir_hi_i    (ir_low_i[11:5]),
        .ctl_o      (ctl)
    );

    accum_alu #(.ACC_W(ACC_W), .CHR_W(CHR_W)) u_alu (
        .op_i    (ctl.op),
        .ac_i    (st_q.ac),
        .e_i     (st_q.e),
        .dr_i    (dr_i),
        .inpr_i  (inpr_i),
        .ac_nx_o (alu_ac),
        .e_nx_o  (alu_e)
    );

    accum_skip #(.ACC_W(ACC_W)) u_skip (
        .rr_act_i (ctl.rr_act),
        .ir_lo_i  (ir_low_i[4:0]),
        .ac_i     (st_q.ac),
        .e_i      (st_q.e),
        .skip_o   (skip_o),
        .halt_o   (halt_o)
    );

    always_comb begin
        st_d = st_q;
        if (ctl.ac_clr)                   st_d.ac = '0;
        else if (ctl.ac_ld || ctl.ac_inr) st_d.ac = alu_ac;
        if (ctl.e_wr)                     st_d.e  = alu_e;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign ac_o = st_q.ac;
    assign e_o  = st_q.e;

    // port-level view of a register-reference cycle, for the checks below
    logic rr_seen;
    assign rr_seen = reg_stb_i & op_dec_i[7] & ~indirect_i;

    assert_add_carry_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (exec_stb_i && op_dec_i == 8'h02) |=>
        ({e_o, ac_o} == ({1'b0, $past(ac_o)} + {1'b0, $past(dr_i)})));

    assert_clear_acc_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (rr_seen && ir_low_i[BIT_ZAC]) |=> (ac_o == '0));

    assert_inc_wrap_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (rr_seen && ir_low_i[11:5] == 7'b0000001) |=>
        (ac_o == $past(ac_o) + 1'b1) && (e_o == $past(e_o)));

    assert_ror_link_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (rr_seen && ir_low_i[11:7] == 5'b00001) |=>
        (e_o == $past(ac_o[0])) && (ac_o[ACC_W-1] == $past(e_o)));

    assert_idle_hold_R14: assert property (@(posedge clk) disable iff (!rst_n)
        (!exec_stb_i && !reg_stb_i) |=> ($stable(ac_o) && $stable(e_o)));

    assert_skip_gate_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (!reg_stb_i) |-> (!skip_o && !halt_o));

endmodule

// File: tb/tb_accum_unit.sv
module tb_accum_unit;

    localparam int W  = 16;
    localparam int CW = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [7:0]    op_dec = '0;
    logic          indirect = 1'b0;
    logic          exec_stb = 1'b0;
    logic          reg_stb = 1'b0;
    logic [11:0]   ir = '0;
    logic [W-1:0]  dr = '0;
    logic [CW-1:0] inpr = '0;
    logic [W-1:0]  ac;
    logic          e, skip, halt;

    always #10 clk = ~clk;   // 50 MHz

    accum_unit dut (
        .clk(clk), .rst_n(rst_n), .op_dec_i(op_dec), .indirect_i(indirect),
        .exec_stb_i(exec_stb), .reg_stb_i(reg_stb), .ir_low_i(ir),
        .dr_i(dr), .inpr_i(inpr), .ac_o(ac), .e_o(e),
        .skip_o(skip), .halt_o(halt)
    );

    int n_chk = 0;
    int n_fail = 0;
    logic [W-1:0] m_ac;
    logic         m_e;
    logic         last_sk, last_hl;
    bit           done = 0;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic idle();
        op_dec = '0; indirect = 0; exec_stb = 0; reg_stb = 0; ir = '0;
    endtask

    task automatic mem_op(input logic [7:0] lines, input logic [W-1:0] d);
        @(negedge clk);
        op_dec = lines; exec_stb = 1; dr = d;
        @(negedge clk);
        idle();
    endtask

    task automatic grp_op(input logic [7:0] lines, input logic ind, input logic [11:0] bits);
        @(negedge clk);
        op_dec = lines; indirect = ind; reg_stb = 1; ir = bits;
        #1;
        last_sk = skip; last_hl = halt;
        @(negedge clk);
        idle();
    endtask

    task automatic model_rr(input logic [11:0] b);
        logic [W-1:0] a;
        logic         x;
        a = m_ac; x = m_e;
        if      (b[11]) m_ac = '0;
        else if (b[10]) m_e  = 1'b0;
        else if (b[9])  m_ac = ~a;
        else if (b[8])  m_e  = ~x;
        else if (b[7])  begin m_ac = {x, a[W-1:1]}; m_e = a[0]; end
        else if (b[6])  begin m_ac = {a[W-2:0], x}; m_e = a[W-1]; end
        else if (b[5])  m_ac = a + 1'b1;
    endtask

    function automatic logic exp_skip(input logic [11:0] b, input logic [W-1:0] a, input logic x);
        return (b[4] & ~a[W-1]) | (b[3] & a[W-1]) | (b[2] & (a == '0)) | (b[1] & ~x);
    endfunction

    task automatic state_chk(input string tag);
        chk({tag, " acc"}, 32'(ac), 32'(m_ac));
        chk({tag, " link"}, 32'(e), 32'(m_e));
    endtask

    task automatic rr(input logic [11:0] b, input string tag);
        grp_op(8'h80, 1'b0, b);
        model_rr(b);
        state_chk(tag);
    endtask

    function automatic logic [W-1:0] pattern(input int i);
        case (i)
            0: return 16'h0000;  1: return 16'hFFFF;
            2: return 16'h8000;  3: return 16'h0001;
            4: return 16'h7FFF;  5: return 16'hFFFE;
            6: return 16'h00FF;  7: return 16'hFF00;
            default: return 16'(i * 40503 + 12345) ^ 16'(i << 7);
        endcase
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog R14 actual=hung expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        idle();
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        m_ac = '0; m_e = 0;
        state_chk("R1 reset");

        // directed wrap corners
        mem_op(8'h04, 16'hFFFF); m_ac = 16'hFFFF;
        mem_op(8'h02, 16'h0001); m_ac = 16'h0000; m_e = 1;
        state_chk("R3 carry-out");
        mem_op(8'h04, 16'hFFFF); m_ac = 16'hFFFF;
        rr(12'h020, "R10 wrap link-kept");
        rr(12'h400, "R6 clear link");
        mem_op(8'h04, 16'hFFFF); m_ac = 16'hFFFF;
        rr(12'h020, "R10 wrap link-zero");

        for (int i = 0; i < 72; i++) begin
            logic [W-1:0] v, w;
            logic [11:0]  pr;
            logic [CW-1:0] ch;
            v = pattern(i);
            w = {v[7:0], v[15:8]} ^ 16'h5A5A;

            mem_op(8'h04, v); m_ac = v;
            state_chk("R4 load");
            rr(12'h400, "R6 clear link");
            if (v[3]) rr(12'h100, "R7 invert link");

            for (int b = 1; b <= 4; b++) begin
                grp_op(8'h80, 1'b0, 12'(1 << b));
                chk("R12 single test", 32'(last_sk), 32'(exp_skip(12'(1 << b), m_ac, m_e)));
            end
            grp_op(8'h80, 1'b0, 12'h01E);
            chk("R12 combined", 32'(last_sk), 32'(exp_skip(12'h01E, m_ac, m_e)));
            state_chk("R12 no side effect");
            grp_op(8'h80, 1'b1, 12'h01E);
            chk("R12 io gated", 32'(last_sk), 32'd0);
            grp_op(8'h80, 1'b0, 12'h001);
            chk("R13 halt", 32'(last_hl), 32'd1);
            grp_op(8'h80, 1'b1, 12'h001);
            chk("R13 io no halt", 32'(last_hl), 32'd0);
            grp_op(8'h40, 1'b0, 12'h001);
            chk("R13 wrong line", 32'(last_hl), 32'd0);

            mem_op(8'h02, w); {m_e, m_ac} = {1'b0, m_ac} + {1'b0, w};
            state_chk("R3 add");
            mem_op(8'h01, w ^ v); m_ac = m_ac & (w ^ v);
            state_chk("R2 and");
            rr(12'h080, "R8 rotate right");
            rr(12'h040, "R9 rotate left");
            rr(12'h200, "R7 invert acc");
            rr(12'h020, "R10 increment");

            ch = v[15:8] ^ 8'(i);
            inpr = ch;
            grp_op(8'h80, 1'b1, 12'h800); m_ac = {m_ac[W-1:CW], ch};
            state_chk("R5 char load");
            grp_op(8'h80, 1'b1, 12'h7FF);
            state_chk("R5 other io bits");

            pr = (v[11:0] & 12'hFE0) | 12'h020;
            rr(pr, "R11 priority");

            mem_op(8'(1 << (3 + (i % 5))), w);
            state_chk("R14 exec other line");
            grp_op(8'(1 << (i % 7)), 1'b0, 12'hFFF);
            state_chk("R14 reg strobe other line");
            chk("R14 no skip", 32'(last_sk), 32'd0);

            rr(12'h800, "R6 clear acc");
        end

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule